// File: doc/BRIEF.md
# Flash Read Line Buffer with Sequential Prefetch

This block sits on the read path between a bus master and a slow flash array that delivers 128-bit pages. It holds four line buffers, each one full aligned page of four 32-bit words. A read whose line is already held completes with no wait states. A read that misses starts one page read on the array side. The array returns the page after a fixed number of cycles (`ACC_WAIT`, two by default). The page is written into a buffer, and the requested word goes back to the master in that same cycle.

When prefetch is enabled for the access type of a missing read, the block reads the next sequential line into a second buffer right after the demand fill. It skips this if that line is already held. A two-bit mode input gates prefetch separately for instruction fetches and data reads. An invalidate input empties every buffer in one cycle.

The request channel is valid/ready. A read completes in the cycle where `req_valid` and `req_ready` are both high, and `rsp_data` carries the word in that cycle. While `req_ready` is low the master must hold `req_valid`, `req_addr` and `req_instr` unchanged. The block applies back-pressure for every cycle of a fetch. The array port takes no back-pressure: one read pulse in, the page out `ACC_WAIT` cycles later, at most one read in flight.

Top module: `line_prefetch_buf`

## Requirements
- R1: A request whose line is held, presented while no fetch is in flight and `inv` is low, completes in the same cycle with the held word and starts no array read.
- R2: A request that misses raises `arr_rd` with its line address in its first cycle and completes exactly `ACC_WAIT` cycles later (two wait states by default) with the word from the array page.
- R3: The line address is `req_addr[31:4]` and the word select is `req_addr[3:2]`, with word k in page bits [32k+31:32k]. `req_addr[1:0]` has no effect.
- R4: A filled line goes to the lowest-numbered empty buffer, or else to the least recently used one. Both hits and fills count as use.
- R5: `pf_mode` bit 0 enables prefetch after instruction misses (`req_instr`=1), and bit 1 enables it after data misses. When enabled, `arr_rd` for line+1 is raised in the cycle of the demand fill.
- R6: No prefetch is started when line+1 is already held in a buffer that is not being replaced by the demand fill.
- R7: `inv` clears all buffers in one cycle. While it is high and no fetch is in flight, no request completes, and every later read of a former line misses.
- R8: If `inv` is high during a fetch, the demand word is still delivered, but the page is not kept and no prefetch follows.
- R9: While a prefetch is in flight, a request to a held line completes without waits (except in the fill cycle). A request to the prefetched line completes in its fill cycle. Any other request waits until the prefetch is done and then misses.
- R10: At most one array read is in flight. `arr_rd` is raised only while the block is idle or in a fill cycle.
- R11: After reset all buffers are empty, `arr_rd` is low and `req_ready` is low without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pf_mode | input | 2 | Prefetch enable: bit 0 instruction, bit 1 data |
| inv | input | 1 | Clear all buffers |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read completes this cycle |
| req_addr | input | 32 | Byte address of the read |
| req_instr | input | 1 | 1 for instruction fetch, 0 for data read |
| rsp_data | output | 32 | Read word, valid with req_valid and req_ready |
| arr_rd | output | 1 | Page read pulse to the array |
| arr_line | output | 28 | Line address of the page read |
| arr_rdata | input | 128 | Page returned ACC_WAIT cycles after arr_rd |

## Verification
The hardest situations to reach are requests that land while a prefetch is in flight. These include a hit during the wait, a request for the line being prefetched in its fill cycle, and a miss that must wait out the whole prefetch. Invalidate arriving in the middle of a demand fetch is similarly hard to reach. The stimulus reaches these by issuing a second read back to back with a demand miss, so it starts in a known cycle of the prefetch. It pulses invalidate in a forked thread one cycle into a fetch. Random reads over a dozen lines, with mode changes and sporadic invalidates, then mix these states further.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_PF   = 2'd2
  } pfb_state_e;

endpackage

// File: rtl/pfb_tags.sv
module pfb_tags #(
  parameter int NUM_BUF = 4,
  parameter int TAG_W   = 28,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [TAG_W-1:0]   nx_tag,
  output logic [NUM_BUF-1:0] valid,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [NUM_BUF-1:0] nx_vec
);

  logic [NUM_BUF-1:0] lk_vec;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (inv) begin
        v_q <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
        t_q <= wr_tag;
      end
    end

    assign valid[g]  = v_q;
    assign lk_vec[g] = v_q && (t_q == lk_tag);
    assign nx_vec[g] = v_q && (t_q == nx_tag);
  end

  assign lk_hit = |lk_vec;

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (lk_vec[i]) lk_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pfb_lru.sv
module pfb_lru #(
  parameter int NUM_BUF = 4,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [NUM_BUF-1:0] valid,
  output logic [IDX_W-1:0]   victim
);

  // rank NUM_BUF-1 = most recent, rank 0 = least recent; ranks stay a permutation
  logic [IDX_W-1:0] rank_q [NUM_BUF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BUF; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (IDX_W'(i) == touch_idx) begin
          rank_q[i] <= IDX_W'(NUM_BUF - 1);
        end else if (rank_q[i] > rank_q[touch_idx]) begin
          rank_q[i] <= rank_q[i] - 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!found && !valid[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (rank_q[i] == '0) victim = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pfb_data.sv
module pfb_data #(
  parameter int NUM_BUF = 4,
  parameter int LINE_W  = 128,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);

  logic [LINE_W-1:0] line_q [NUM_BUF];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_idx] <= wr_line;
  end

  assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int NUM_BUF  = 4,
  parameter int TAG_W    = 28,
  parameter int WSEL_W   = 2,
  parameter int ACC_WAIT = 2,
  localparam int IDX_W   = $clog2(NUM_BUF),
  localparam int CNT_W   = $clog2(ACC_WAIT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pf_mode,
  input  logic               inv,
  input  logic               req_valid,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [WSEL_W-1:0]  req_wsel,
  input  logic               req_instr,
  input  logic               lk_hit,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic [NUM_BUF-1:0] nx_vec,
  input  logic [IDX_W-1:0]   victim,
  output logic               req_ready,
  output logic               fwd,
  output logic [WSEL_W-1:0]  fwd_wsel,
  output logic               touch_en,
  output logic [IDX_W-1:0]   touch_idx,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [TAG_W-1:0]   wr_tag,
  output logic               arr_rd,
  output logic [TAG_W-1:0]   arr_tag,
  output logic [TAG_W-1:0]   nx_tag
);

  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ACC_WAIT - 1);

  pfb_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [TAG_W-1:0]   f_tag_q;
  logic [WSEL_W-1:0]  f_wsel_q;
  logic               f_instr_q;
  logic               poison_q;

  logic               cap;
  logic               keep;
  logic               mode_ok;
  logic               nx_present;
  logic               pf_go;
  logic               start_miss;
  logic [NUM_BUF-1:0] victim_oh;

  assign cap     = (cnt_q == '0);
  assign keep    = !poison_q && !inv;
  assign mode_ok = f_instr_q ? pf_mode[0] : pf_mode[1];
  assign nx_tag  = f_tag_q + 1'b1;

  always_comb begin
    victim_oh = '0;
    victim_oh[victim] = 1'b1;
  end

  // the buffer being overwritten by the demand fill no longer counts as holding line+1
  assign nx_present = |(nx_vec & ~victim_oh);
  assign pf_go      = (state_q == ST_MISS) && cap && keep && mode_ok && !nx_present;
  assign start_miss = (state_q == ST_IDLE) && req_valid && !inv && !lk_hit;

  always_comb begin
    req_ready = 1'b0;
    fwd       = 1'b0;
    fwd_wsel  = f_wsel_q;
    touch_en  = 1'b0;
    touch_idx = lk_idx;
    wr_en     = 1'b0;
    wr_idx    = victim;
    wr_tag    = f_tag_q;
    arr_rd    = 1'b0;
    arr_tag   = req_tag;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !inv) begin
          if (lk_hit) begin
            req_ready = 1'b1;
            touch_en  = 1'b1;
          end else begin
            arr_rd = 1'b1;
          end
        end
      end
      ST_MISS: begin
        if (cap) begin
          req_ready = 1'b1;
          fwd       = 1'b1;
          if (keep) begin
            wr_en     = 1'b1;
            touch_en  = 1'b1;
            touch_idx = victim;
          end
          if (pf_go) begin
            arr_rd  = 1'b1;
            arr_tag = nx_tag;
          end
        end
      end
      ST_PF: begin
        if (!cap) begin
          if (req_valid && !inv && lk_hit) begin
            req_ready = 1'b1;
            touch_en  = 1'b1;
          end
        end else if (keep) begin
          wr_en     = 1'b1;
          touch_en  = 1'b1;
          touch_idx = victim;
          if (req_valid && req_tag == f_tag_q) begin
            req_ready = 1'b1;
            fwd       = 1'b1;
            fwd_wsel  = req_wsel;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      f_tag_q   <= '0;
      f_wsel_q  <= '0;
      f_instr_q <= 1'b0;
      poison_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_miss) begin
            state_q   <= ST_MISS;
            cnt_q     <= CNT_INIT;
            f_tag_q   <= req_tag;
            f_wsel_q  <= req_wsel;
            f_instr_q <= req_instr;
            poison_q  <= 1'b0;
          end
        end
        ST_MISS: begin
          if (cap) begin
            if (pf_go) begin
              state_q  <= ST_PF;
              cnt_q    <= CNT_INIT;
              f_tag_q  <= nx_tag;
              poison_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (inv) poison_q <= 1'b1;
          end
        end
        ST_PF: begin
          if (cap) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (inv) poison_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/line_prefetch_buf.sv
module line_prefetch_buf #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_BUF    = 4,
  parameter int ACC_WAIT   = 2,
  localparam int LINE_W    = WORD_W * LINE_WORDS,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int BYTE_W    = $clog2(WORD_W / 8),
  localparam int OFF_W     = WSEL_W + BYTE_W,
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pf_mode,
  input  logic              inv,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_instr,
  output logic [WORD_W-1:0] rsp_data,
  output logic              arr_rd,
  output logic [TAG_W-1:0]  arr_line,
  input  logic [LINE_W-1:0] arr_rdata
);

  logic [TAG_W-1:0]   req_tag;
  logic [WSEL_W-1:0]  req_wsel;
  logic               unused_low;
  logic [NUM_BUF-1:0] valid;
  logic               lk_hit;
  logic [IDX_W-1:0]   lk_idx;
  logic [NUM_BUF-1:0] nx_vec;
  logic [TAG_W-1:0]   nx_tag;
  logic [IDX_W-1:0]   victim;
  logic               fwd;
  logic [WSEL_W-1:0]  fwd_wsel;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [TAG_W-1:0]   wr_tag;
  logic [LINE_W-1:0]  rd_line;

  assign req_tag    = req_addr[ADDR_W-1:OFF_W];
  assign req_wsel   = req_addr[OFF_W-1:BYTE_W];
  assign unused_low = ^req_addr[BYTE_W-1:0];

  pfb_tags #(.NUM_BUF(NUM_BUF), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .inv    (inv),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_tag (wr_tag),
    .lk_tag (req_tag),
    .nx_tag (nx_tag),
    .valid  (valid),
    .lk_hit (lk_hit),
    .lk_idx (lk_idx),
    .nx_vec (nx_vec)
  );

  pfb_lru #(.NUM_BUF(NUM_BUF)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .valid     (valid),
    .victim    (victim)
  );

  pfb_data #(.NUM_BUF(NUM_BUF), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_line (arr_rdata),
    .rd_idx  (lk_idx),
    .rd_line (rd_line)
  );

  pfb_ctrl #(
    .NUM_BUF  (NUM_BUF),
    .TAG_W    (TAG_W),
    .WSEL_W   (WSEL_W),
    .ACC_WAIT (ACC_WAIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pf_mode   (pf_mode),
    .inv       (inv),
    .req_valid (req_valid),
    .req_tag   (req_tag),
    .req_wsel  (req_wsel),
    .req_instr (req_instr),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .nx_vec    (nx_vec),
    .victim    (victim),
    .req_ready (req_ready),
    .fwd       (fwd),
    .fwd_wsel  (fwd_wsel),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tag    (wr_tag),
    .arr_rd    (arr_rd),
    .arr_tag   (arr_line),
    .nx_tag    (nx_tag)
  );

  always_comb begin
    if (fwd) rsp_data = arr_rdata[fwd_wsel*WORD_W +: WORD_W];
    else     rsp_data = rd_line[req_wsel*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/line_prefetch_buf_chk.sv
module line_prefetch_buf_chk #(
  parameter int ACC_WAIT = 2,
  localparam int OC_W    = $clog2(ACC_WAIT + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pf_mode,
  input logic       inv,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_instr,
  input logic       arr_rd
);

  // cycles left on the array read in flight; 1 marks its fill cycle
  logic [OC_W-1:0] ocnt;
  logic            dem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt <= '0;
      dem  <= 1'b0;
    end else begin
      if (arr_rd) begin
        ocnt <= OC_W'(ACC_WAIT);
        dem  <= (ocnt == '0);
      end else if (ocnt != '0) begin
        ocnt <= ocnt - 1'b1;
      end
    end
  end

  p_one_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd |-> (ocnt <= OC_W'(1)));

  p_miss_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt == OC_W'(1) && dem) |-> req_ready);

  p_miss_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt > OC_W'(1) && dem) |-> !req_ready);

  p_hit_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ocnt == '0) |-> !arr_rd);

  p_inv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv && ocnt == '0) |-> !req_ready);

  p_pf_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && ocnt == OC_W'(1) && dem) |-> (req_instr ? pf_mode[0] : pf_mode[1]));

endmodule

bind line_prefetch_buf line_prefetch_buf_chk #(.ACC_WAIT(ACC_WAIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pf_mode   (pf_mode),
  .inv       (inv),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_instr (req_instr),
  .arr_rd    (arr_rd)
);

// File: tb/sim_line_prefetch_buf.sv
module sim_line_prefetch_buf;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   pf_mode = 2'b00;
  logic         inv = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_instr = 1'b0;
  logic [31:0]  rsp_data;
  logic         arr_rd;
  logic [27:0]  arr_line;
  logic [127:0] arr_rdata;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [27:0] last_line = '0;
  logic [27:0] d1 = '0;
  logic [27:0] d2 = '0;

  always #4 clk = ~clk;

  line_prefetch_buf u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pf_mode   (pf_mode),
    .inv       (inv),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_instr (req_instr),
    .rsp_data  (rsp_data),
    .arr_rd    (arr_rd),
    .arr_line  (arr_line),
    .arr_rdata (arr_rdata)
  );

  function automatic logic [31:0] wexp(logic [27:0] line, int k);
    return ({4'h0, line} * 32'h9E3779B1) ^ (32'(k) * 32'h85EBCA6B) ^ 32'h5A5A1234;
  endfunction

  // array model: page appears two cycles after the read pulse
  always @(posedge clk) begin
    d1 <= arr_line;
    d2 <= d1;
  end

  always_comb begin
    for (int k = 0; k < 4; k++) arr_rdata[k*32 +: 32] = wexp(d2, k);
  end

  always @(negedge clk) begin
    #3;
    if (rst_n && arr_rd) begin
      rd_cnt++;
      last_line = arr_line;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // starts and ends at a falling edge; w counts wait cycles
  task automatic rd(input logic [31:0] a, input logic ins, output int w, output logic [31:0] d);
    req_valid = 1'b1;
    req_addr  = a;
    req_instr = ins;
    w = 0;
    #1;
    while (!req_ready && w < 40) begin
      @(posedge clk);
      #1;
      w++;
    end
    d = rsp_data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_inv();
    inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
  endtask

  task automatic rdc(string rq, logic [31:0] a, logic ins, int ew);
    int w;
    logic [31:0] d;
    rd(a, ins, w, d);
    chk({rq, " waits"}, 32'(w), 32'(ew));
    chk({rq, " data"}, d, wexp(a[31:4], int'(a[3:2])));
  endtask

  initial begin : watchdog
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int w;
    int w2;
    logic [31:0] d;
    logic [31:0] d2v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 arr_rd in reset", 32'(arr_rd), 0);
    chk("R11 ready in reset", 32'(req_ready), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R11 ready idle", 32'(req_ready), 0);
    chk("R11 arr_rd idle", 32'(arr_rd), 0);

    // R2 miss, R1 hit, R3 word select
    rd_cnt = 0;
    rdc("R2 first miss", 32'h100, 1'b1, 2);
    idle(3);
    chk("R2 one array read", 32'(rd_cnt), 1);
    chk("R2 array line", 32'(last_line), 32'h10);
    rdc("R1 hit word1", 32'h104, 1'b0, 0);
    rdc("R3 low bits ignored", 32'h10B, 1'b1, 0);
    rdc("R3 word3", 32'h10C, 1'b0, 0);
    chk("R1 no array read on hit", 32'(rd_cnt), 1);

    // R4 LRU replacement
    pulse_inv();
    rdc("R4 fill A", 32'h1000, 1'b0, 2);
    rdc("R4 fill B", 32'h2000, 1'b0, 2);
    rdc("R4 fill C", 32'h3000, 1'b0, 2);
    rdc("R4 fill D", 32'h4000, 1'b0, 2);
    rdc("R4 touch A", 32'h1004, 1'b0, 0);
    rdc("R4 E evicts B", 32'h5000, 1'b0, 2);
    rdc("R4 B was evicted", 32'h2000, 1'b0, 2);
    rdc("R4 A kept", 32'h1008, 1'b0, 0);
    rdc("R4 D kept", 32'h4008, 1'b0, 0);
    rdc("R4 C was evicted", 32'h3000, 1'b0, 2);

    // R7 invalidate
    req_valid = 1'b1; req_addr = 32'h4000; req_instr = 1'b0; inv = 1'b1;
    #1;
    chk("R7 no completion during inv", 32'(req_ready), 0);
    @(negedge clk);
    inv = 1'b0; req_valid = 1'b0;
    rdc("R7 miss after inv", 32'h4000, 1'b0, 2);
    rdc("R7 miss after inv other", 32'h1000, 1'b0, 2);

    // R5 prefetch modes
    pf_mode = 2'b01; pulse_inv(); rd_cnt = 0;
    rdc("R5 instr miss", 32'h200, 1'b1, 2);
    idle(4);
    chk("R5 instr prefetch count", 32'(rd_cnt), 2);
    chk("R5 prefetch line", 32'(last_line), 32'h21);
    rdc("R5 prefetched hit", 32'h214, 1'b1, 0);
    rd_cnt = 0;
    rdc("R5 data miss mode01", 32'h300, 1'b0, 2);
    idle(4);
    chk("R5 no data prefetch mode01", 32'(rd_cnt), 1);
    rdc("R5 next data line misses", 32'h310, 1'b0, 2);
    pf_mode = 2'b10; idle(4); rd_cnt = 0;
    rdc("R5 data miss mode10", 32'h400, 1'b0, 2);
    idle(4);
    chk("R5 data prefetch mode10", 32'(rd_cnt), 2);
    rdc("R5 data prefetched hit", 32'h418, 1'b0, 0);
    rd_cnt = 0;
    rdc("R5 instr miss mode10", 32'h500, 1'b1, 2);
    idle(4);
    chk("R5 no instr prefetch mode10", 32'(rd_cnt), 1);

    // R6 next line already held
    pf_mode = 2'b00; pulse_inv();
    rdc("R6 preload next line", 32'h610, 1'b1, 2);
    pf_mode = 2'b11; rd_cnt = 0;
    rdc("R6 miss with next held", 32'h600, 1'b1, 2);
    idle(4);
    chk("R6 no prefetch", 32'(rd_cnt), 1);

    // R9 requests during a prefetch
    pulse_inv();
    rdc("R9 demand miss", 32'h700, 1'b1, 2);
    rdc("R9 request to prefetched line", 32'h714, 1'b1, 1);
    pulse_inv(); idle(2);
    rdc("R9 demand miss 2", 32'h800, 1'b0, 2);
    rdc("R9 hit during prefetch", 32'h804, 1'b0, 0);
    rdc("R9 other miss at fill cycle", 32'h900, 1'b0, 3);
    idle(4);
    rdc("R9 prefetch kept", 32'h818, 1'b0, 0);
    pulse_inv(); idle(2);
    rdc("R9 demand miss 3", 32'hA00, 1'b1, 2);
    rdc("R9 other miss waits out prefetch", 32'hC00, 1'b1, 4);
    idle(4);

    // R8 invalidate during a demand fetch
    pulse_inv(); idle(2); rd_cnt = 0;
    fork
      rd(32'hB04, 1'b1, w, d);
      begin
        @(posedge clk); #2; inv = 1'b1;
        @(posedge clk); #2; inv = 1'b0;
      end
    join
    chk("R8 waits", 32'(w), 2);
    chk("R8 word delivered", d, wexp(28'hB0, 1));
    idle(4);
    chk("R8 no prefetch", 32'(rd_cnt), 1);
    rd(32'hB08, 1'b1, w2, d2v);
    chk("R8 page not kept", 32'(w2), 2);
    chk("R8 refetch data", d2v, wexp(28'hB0, 2));
    idle(4);

    // random mix: data must match the page function, bounded waits
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin
        pulse_inv();
      end else if (r < 8) begin
        pf_mode = 2'($urandom_range(0, 3));
      end else begin
        a = {20'h0, 4'($urandom_range(0, 11)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))} + 32'h3000;
        rd(a, 1'($urandom_range(0, 1)), w, d);
        chk("R3 random data", d, wexp(a[31:4], int'(a[3:2])));
        if (w > 4) chk("R9 random wait bound", 32'(w), 4);
        if ($urandom_range(0, 3) == 0) idle(1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule